// File: doc/BRIEF.md
# ECC-Driven Defective Line Retirement Controller

This controller sits next to a cache's ECC checker and its tag array. The checker hands it one correctable-error report at a time, each naming a cache line index. The controller uses the error history of each line to tell a transient upset from a hard defect. A line that errs for the first time has its data corrected and is remembered in a small history table. A line that errs again while it is still remembered is retired. Retiring a line means a one-cycle command that writes a reserved never-valid coherence code into that line's tag.

A second policy can be picked per report with `mode_reread`. In this mode the controller asks the cache to write the corrected data back and read the line again. It retires the line only if that reread still reports an error. The history table is neither searched nor changed in this mode. A small guard output flags any tag state that holds the never-valid code, so that lookup and allocation logic can refuse such a line. A saturating counter reports how many lines have been retired so far.

The control flow is a five-state machine:
- IDLE accepts a report. It moves to LOOKUP when `mode_reread` is low and to REWRITE when it is high.
- LOOKUP searches the table. On a hit it moves to RETIRE. On a miss it writes the line into the table and returns to IDLE.
- RETIRE issues the disable command and returns to IDLE.
- REWRITE issues the write-back-and-reread request and moves to AWAIT.
- AWAIT holds until `rw_done`. It then moves to RETIRE if `rw_err` is set, and to IDLE if it is not.

Top module: `line_retire_ctrl`

## Requirements
- R1: `err_ready` is high only in IDLE. A report is taken when `err_valid` and `err_ready` are both high, and `err_ready` then stays low until the report has been fully handled.
- R2: In history mode, a report whose line is not held in the table causes no disable command. The line is added to the table.
- R3: In history mode, a report whose line is held in the table causes exactly one disable command. That command carries the line in `dis_line` and the never-valid code 3'b111 in `dis_state`. The coherence codes are 000 invalid, 001 shared, 010 exclusive, 011 modified and 111 never-valid.
- R4: The table holds ENTRIES lines. Each new line overwrites the entry that was inserted earliest (FIFO order), and a hit inserts nothing. After a line has been evicted, its next error counts as a first error again.
- R5: With `mode_reread` high when a report is accepted, `rw_req` pulses for one cycle with the line on `rw_line`. The controller then waits for `rw_done` and retires the line only if `rw_err` is high at `rw_done`. The table is left unchanged.
- R6: `dis_valid` is high for exactly one cycle per retirement. It returns to IDLE afterwards.
- R7: `probe_blocked` is high exactly when `probe_state` equals 3'b111, so that no line in that state is hit or allocated.
- R8: `dis_count` increments by one for each disable command and saturates at 2^CNT_W-1.
- R9: After reset, `dis_count` is zero, the table is empty, no command is active, and `err_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_reread | input | 1 | 1 selects confirm-by-reread for the report being accepted |
| err_valid | input | 1 | Error report present |
| err_ready | output | 1 | Controller can take a report |
| err_line | input | IDX_W | Line index of the erring line |
| rw_req | output | 1 | One-cycle request to write back corrected data and reread |
| rw_line | output | IDX_W | Line to write back and reread |
| rw_done | input | 1 | Reread finished |
| rw_err | input | 1 | Reread still showed an ECC error (valid with rw_done) |
| dis_valid | output | 1 | One-cycle tag write command that retires a line |
| dis_line | output | IDX_W | Line whose tag is written |
| dis_state | output | 3 | Coherence code written (always never-valid) |
| dis_count | output | CNT_W | Saturating number of retired lines |
| probe_state | input | 3 | Coherence code read from a tag |
| probe_blocked | output | 1 | The probed tag is never-valid |

## Verification
The properties assume that the cache side raises `rw_done` only while the controller is waiting after an `rw_req`, and only for one cycle. They also assume that `err_line` and `mode_reread` are steady while `err_valid` is high. The stimulus enforces both. It raises `rw_done` only after it has seen the request pulse and drops it one cycle later. It changes the mode and the line only between reports, while the controller is idle. Each report waits until `err_ready` returns, so no report is ever presented while the controller is busy.

// File: rtl/line_retire_pkg.sv
package line_retire_pkg;

    // Coherence codes held in a tag; 3'b111 is reserved for retired lines.
    typedef enum logic [2:0] {
        COH_INVALID  = 3'b000,
        COH_SHARED   = 3'b001,
        COH_EXCL     = 3'b010,
        COH_MODIFIED = 3'b011,
        COH_NEVER    = 3'b111
    } coh_state_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_RETIRE,
        ST_REWRITE,
        ST_AWAIT
    } ctl_state_e;

endpackage

// File: rtl/retire_table.sv
module retire_table #(
    parameter int IDX_W   = 6,
    parameter int ENTRIES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_line,
    input  logic [IDX_W-1:0] lk_line,
    output logic             lk_hit
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    logic [PTR_W-1:0]  wptr;
    logic [ENTRIES-1:0] vld;
    logic [IDX_W-1:0]  line_q [ENTRIES];
    logic [ENTRIES-1:0] match;

    // FIFO insertion: the pointer always names the earliest-written slot once full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            vld  <= '0;
            for (int i = 0; i < ENTRIES; i++) line_q[i] <= '0;
        end else if (wr_en) begin
            vld[wptr]    <= 1'b1;
            line_q[wptr] <= wr_line;
            wptr         <= (wptr == LAST) ? '0 : wptr + 1'b1;
        end
    end

    // Parallel compare across all slots.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld[g] && (line_q[g] == lk_line);
    end

    assign lk_hit = |match;
endmodule

// File: rtl/retire_counter.sv
module retire_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)                     count <= '0;
        else if (inc && count != TOP)   count <= count + 1'b1;
    end
endmodule

// File: rtl/coh_guard.sv
module coh_guard
    import line_retire_pkg::*;
(
    input  logic [2:0] tag_state,
    output logic       blocked
);
    assign blocked = (tag_state == COH_NEVER);
endmodule

// File: rtl/line_retire_ctrl.sv
module line_retire_ctrl
    import line_retire_pkg::*;
#(
    parameter int IDX_W   = 6,
    parameter int ENTRIES = 4,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_reread,
    input  logic             err_valid,
    output logic             err_ready,
    input  logic [IDX_W-1:0] err_line,
    output logic             rw_req,
    output logic [IDX_W-1:0] rw_line,
    input  logic             rw_done,
    input  logic             rw_err,
    output logic             dis_valid,
    output logic [IDX_W-1:0] dis_line,
    output logic [2:0]       dis_state,
    output logic [CNT_W-1:0] dis_count,
    input  logic [2:0]       probe_state,
    output logic             probe_blocked
);
    ctl_state_e       state, state_nx;
    logic [IDX_W-1:0] cap_line;
    logic             tbl_hit, tbl_wr;

    retire_table #(.IDX_W(IDX_W), .ENTRIES(ENTRIES)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr), .wr_line(cap_line),
        .lk_line(cap_line), .lk_hit(tbl_hit)
    );

    retire_counter #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .inc(dis_valid), .count(dis_count)
    );

    coh_guard u_guard (.tag_state(probe_state), .blocked(probe_blocked));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Captured report
    always_ff @(posedge clk) begin
        if (!rst_n)                        cap_line <= '0;
        else if (err_valid && err_ready)   cap_line <= err_line;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (err_valid) state_nx = mode_reread ? ST_REWRITE : ST_LOOKUP;
            ST_LOOKUP:  state_nx = tbl_hit ? ST_RETIRE : ST_IDLE;
            ST_RETIRE:  state_nx = ST_IDLE;
            ST_REWRITE: state_nx = ST_AWAIT;
            ST_AWAIT:   if (rw_done) state_nx = rw_err ? ST_RETIRE : ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        err_ready = 1'b0;
        tbl_wr    = 1'b0;
        dis_valid = 1'b0;
        rw_req    = 1'b0;
        unique case (state)
            ST_IDLE:    err_ready = 1'b1;
            ST_LOOKUP:  tbl_wr    = !tbl_hit;
            ST_RETIRE:  dis_valid = 1'b1;
            ST_REWRITE: rw_req    = 1'b1;
            ST_AWAIT:   ;
            default:    ;
        endcase
    end

    assign rw_line   = cap_line;
    assign dis_line  = cap_line;
    assign dis_state = COH_NEVER;
endmodule

// File: rtl/line_retire_chk.sv
module line_retire_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             err_valid,
    input logic             err_ready,
    input logic             rw_req,
    input logic             dis_valid,
    input logic [2:0]       dis_state,
    input logic [CNT_W-1:0] dis_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_ready) |=> !err_ready);                                  // R1
    AST_NOT_READY_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        dis_valid |-> !err_ready);                                                 // R1
    AST_NEVER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        dis_valid |-> (dis_state == 3'b111));                                      // R3
    AST_RW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rw_req |=> !rw_req);                                                       // R5
    AST_DIS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dis_valid |=> (!dis_valid && err_ready));                                  // R6
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_valid && dis_count != CNT_MAX) |=> dis_count == CNT_W'($past(dis_count) + 1'b1)); // R8
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dis_valid |=> $stable(dis_count));                                        // R8
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_count == CNT_MAX) |=> (dis_count == CNT_MAX));                        // R8
endmodule

bind line_retire_ctrl line_retire_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_ready(err_ready),
    .rw_req(rw_req), .dis_valid(dis_valid), .dis_state(dis_state), .dis_count(dis_count)
);

// File: tb/line_retire_ctrl_test.sv
module line_retire_ctrl_test;
    localparam int IDX_W   = 6;
    localparam int ENTRIES = 4;
    localparam int CNT_W   = 4;
    localparam int CNT_MAX = 15;

    logic clk = 1'b0, rst_n = 1'b0, mode_reread = 1'b0, err_valid = 1'b0;
    logic rw_done = 1'b0, rw_err = 1'b0;
    logic [IDX_W-1:0] err_line = '0;
    logic [2:0] probe_state = '0;
    logic err_ready, rw_req, dis_valid, probe_blocked;
    logic [IDX_W-1:0] rw_line, dis_line;
    logic [2:0] dis_state;
    logic [CNT_W-1:0] dis_count;

    int vectors = 0, miscompares = 0;
    int m_tab [ENTRIES];
    bit m_vld [ENTRIES];
    int m_wp = 0, m_cnt = 0;

    always #10 clk = ~clk;

    line_retire_ctrl #(.IDX_W(IDX_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .mode_reread(mode_reread),
        .err_valid(err_valid), .err_ready(err_ready), .err_line(err_line),
        .rw_req(rw_req), .rw_line(rw_line), .rw_done(rw_done), .rw_err(rw_err),
        .dis_valid(dis_valid), .dis_line(dis_line), .dis_state(dis_state),
        .dis_count(dis_count), .probe_state(probe_state), .probe_blocked(probe_blocked)
    );

    task automatic check(string tag, int act, int exp, string what);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One report, with the reference model updated from the requirements.
    task automatic send(int line, bit rr_err);
        bit exp_dis = 0, hit = 0;
        int pulses = 0, last = -1, st = -1, rwseen = 0, rwl = -1, guard = 0;
        string tag;
        if (mode_reread) begin
            exp_dis = rr_err;                                   // R5
            tag = "R5";
        end else begin
            for (int j = 0; j < ENTRIES; j++)
                if (m_vld[j] && m_tab[j] == line) hit = 1;
            exp_dis = hit;
            if (!hit) begin                                     // R4 FIFO insert
                m_tab[m_wp] = line; m_vld[m_wp] = 1; m_wp = (m_wp + 1) % ENTRIES;
            end
            tag = hit ? "R3" : "R2/R4";
        end
        if (exp_dis && m_cnt < CNT_MAX) m_cnt++;

        @(negedge clk); err_valid = 1'b1; err_line = IDX_W'(line);
        @(posedge clk);
        @(negedge clk); err_valid = 1'b0;
        check("R1", int'(err_ready), 0, "ready after accept");
        while (guard < 20) begin
            guard++;
            if (dis_valid) begin pulses++; last = int'(dis_line); st = int'(dis_state); end
            if (rw_req) begin
                rwseen++; rwl = int'(rw_line);
                @(negedge clk); rw_done = 1'b1; rw_err = rr_err;
                @(negedge clk); rw_done = 1'b0; rw_err = 1'b0;
                continue;
            end
            if (err_ready) break;
            @(negedge clk);
        end
        check(tag, (pulses > 0) ? 1 : 0, int'(exp_dis), "disable issued");
        check("R6", (pulses <= 1) ? 1 : 0, 1, "single disable pulse");
        if (exp_dis) begin
            check("R3", last, line, "disable line");
            check("R3", st, 7, "never-valid code");
        end
        check("R5", rwseen, mode_reread ? 1 : 0, "reread requests");
        if (mode_reread) check("R5", rwl, line, "reread line");
        check("R8", int'(dis_count), m_cnt, "retired count");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int j = 0; j < ENTRIES; j++) begin m_tab[j] = 0; m_vld[j] = 0; end
        repeat (3) @(negedge clk);
        check("R9", int'(err_ready), 1, "ready in reset");
        check("R9", int'(dis_valid), 0, "no disable in reset");
        check("R9", int'(rw_req), 0, "no reread in reset");
        check("R9", int'(dis_count), 0, "count in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(err_ready), 1, "ready when idle");

        // R7: every coherence code through the guard
        for (int p = 0; p < 8; p++) begin
            probe_state = 3'(p); #1;
            check("R7", int'(probe_blocked), (p == 7) ? 1 : 0, "blocked flag");
        end

        // History mode: sweep all lines once, then repeats and evictions (R2, R3, R4)
        for (int k = 0; k < 64; k++) send(k, 1'b0);
        send(63, 1'b0);
        send(60, 1'b0);
        send(0, 1'b0);
        send(60, 1'b0);
        send(61, 1'b0);
        for (int i = 0; i < 20; i++) begin
            int l;
            l = (i * 9 + 5) % 64;
            send(l, 1'b0);
            send((l + 32) % 64, 1'b0);
            send(l, 1'b0);
        end

        // Reread mode: alternate reread outcomes (R5)
        @(negedge clk); mode_reread = 1'b1;
        for (int i = 0; i < 16; i++) send(i * 4, 1'(i % 2));
        send((19 * 9 + 5) % 64, 1'b0);

        // Back to history mode: table unchanged by reread reports
        @(negedge clk); mode_reread = 1'b0;
        send(((19 * 9 + 5) % 64 + 32) % 64, 1'b0);
        send(1, 1'b0);
        send(1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule